// File: doc/BRIEF.md
# Trap State Stack

This block keeps processor context across nested traps. When a trap is accepted, the current condition codes, address-space identifier, processor state and window pointer are packed into one state word. That word, the PC, the next PC and the trap type are stored in the frame slot for the current trap level. The processor state is then forced to privileged mode with the floating-point unit enabled and the alternate global register set selected. A vector address is built from the trap base, and the trap level increments.

There are two kinds of return. A "done" return resumes after the trapped instruction. A "retry" return re-executes it. Both kinds decrement the level, read the frame at the new level, and present the unpacked state fields on the outputs.

Near the top of the stack, the block sets the red-state bit instead of overflowing. A trap that arrives when the stack is already full is refused and flagged.

Top module: `trap_state_stack`

## Requirements
- R1: After synchronous reset the trap level is 0, and all outputs are 0: `redir_valid`, `restore_valid`, both error pulses, PC, next PC and state fields.
- R2: A trap request at level L < MAXTL is taken. On the next clock edge the level becomes L+1 and `redir_valid` pulses high for one cycle.
- R3: A taken trap drives `out_pstate` to 0x015, which is bit 4 (FPU enable), bit 2 (privileged) and bit 0 (alternate globals). When L equals MAXTL-1, bit 5 (red state) is also set, giving 0x035.
- R4: For a taken trap, `redir_pc` is the trap base with bits 14:0 replaced. Bit 14 is 1 when L > 1. Bits 13:5 carry the 9-bit trap type, and bits 4:0 are 0. `redir_npc` is `redir_pc` + 4.
- R5: A trap request at level MAXTL is not taken. The level is unchanged, `redir_valid` stays low, and `err_full` pulses for one cycle.
- R6: A "done" return at level L > 0 sets the level to L-1. It drives `redir_pc` to the next PC saved at level L-1 and `redir_npc` to that value + 4. It raises `restore_valid` and restores ccr, asi, pstate, cwp and the trap type that were saved with that frame.
- R7: A "retry" return at level L > 0 sets the level to L-1. It drives `redir_pc` to the saved PC and `redir_npc` to the saved next PC, and restores the same fields as R6.
- R8: A return at level 0 is ignored. The level stays 0, `redir_valid` stays low, and `err_empty` pulses for one cycle.
- R9: A trap request takes priority over a return in the same cycle, even when the trap is refused. When both return kinds are requested together, "done" wins.
- R10: Frames are stored and restored in LIFO order, so interleaved trap and return sequences restore each frame's own values. Internally each frame holds its state as {ccr at 39:32, asi at 31:24, pstate at 19:8, cwp at 7:0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Trap entry request (one cycle) |
| trap_type | input | TT_W | Trap type code |
| done_req | input | 1 | Return that resumes after the trapped instruction |
| retry_req | input | 1 | Return that re-executes the trapped instruction |
| trap_base | input | ADDR_W | Trap table base address |
| cur_pc | input | ADDR_W | Current PC |
| cur_npc | input | ADDR_W | Current next PC |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | 8 | Current window pointer |
| redir_valid | output | 1 | New PC/next PC valid (one cycle) |
| redir_pc | output | ADDR_W | New PC |
| redir_npc | output | ADDR_W | New next PC |
| restore_valid | output | 1 | Restored fields valid (return) |
| out_pstate | output | 12 | Forced (trap) or restored (return) processor state |
| ret_ccr | output | 8 | Restored condition codes |
| ret_asi | output | 8 | Restored address-space identifier |
| ret_cwp | output | 8 | Restored window pointer |
| ret_tt | output | TT_W | Trap type of the frame being returned from |
| trap_level | output | LVL_W | Current trap level |
| err_full | output | 1 | Trap refused at MAXTL (one cycle) |
| err_empty | output | 1 | Return refused at level 0 (one cycle) |

## Verification
The bench fills the stack to MAXTL and then pushes one more trap. A design that let the level wrap, or wrote past the last frame, would report a redirect or a changed level at that point instead of `err_full`.

It drains the stack with alternating done and retry returns and adds one extra return at level 0. Swapped PC/next-PC selection and lost frames show up as wrong addresses. A missed empty check shows up as a level underflow.

The vector bit 14 threshold (level above 1, not at or above 1) and the red-state bit, which only appears at MAXTL-1, are checked on every push under two different trap bases. Priority checks combine a trap with a return at level 0 and at a full stack, and combine done with retry.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
  localparam int CCR_W = 8;
  localparam int ASI_W = 8;
  localparam int PST_W = 12;
  localparam int CWP_W = 8;
  localparam int SW_W  = 40;

  // processor-state bit positions used when forcing state on entry
  localparam int PST_AG   = 0;
  localparam int PST_PRIV = 2;
  localparam int PST_PEF  = 4;
  localparam int PST_RED  = 5;

  localparam logic [PST_W-1:0] PST_ENTRY =
    PST_W'((1 << PST_PEF) | (1 << PST_PRIV) | (1 << PST_AG));
  localparam logic [PST_W-1:0] PST_REDBIT = PST_W'(1 << PST_RED);

  typedef struct packed {
    logic [CCR_W-1:0] ccr;
    logic [ASI_W-1:0] asi;
    logic [PST_W-1:0] pst;
    logic [CWP_W-1:0] cwp;
  } ctx_t;

  function automatic logic [SW_W-1:0] pack_ctx(input ctx_t c);
    return {c.ccr, c.asi, 4'b0000, c.pst, c.cwp};
  endfunction

  function automatic ctx_t unpack_ctx(input logic [SW_W-1:0] w);
    ctx_t c;
    c.ccr = w[39:32];
    c.asi = w[31:24];
    c.pst = w[19:8];
    c.cwp = w[7:0];
    return c;
  endfunction
endpackage

// File: rtl/tstk_level_ctrl.sv
module tstk_level_ctrl #(
  parameter int MAXTL = 5,
  parameter int LVL_W = $clog2(MAXTL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trap_req,
  input  logic             done_req,
  input  logic             retry_req,
  output logic [LVL_W-1:0] tl,
  output logic             take_trap,
  output logic             take_ret,
  output logic             ret_done,
  output logic             reject_trap,
  output logic             reject_ret,
  output logic             red_entry,
  output logic             deep_entry
);
  localparam logic [LVL_W-1:0] TL_MAX  = LVL_W'(MAXTL);
  localparam logic [LVL_W-1:0] TL_NEAR = LVL_W'(MAXTL - 1);

  logic any_ret;

  always_comb begin
    any_ret     = (done_req || retry_req) && !trap_req;
    take_trap   = trap_req && (tl != TL_MAX);
    reject_trap = trap_req && (tl == TL_MAX);
    take_ret    = any_ret && (tl != '0);
    reject_ret  = any_ret && (tl == '0);
    ret_done    = done_req;
    red_entry   = (tl >= TL_NEAR);
    deep_entry  = (tl > LVL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)            tl <= '0;
    else if (take_trap) tl <= tl + LVL_W'(1);
    else if (take_ret)  tl <= tl - LVL_W'(1);
  end

  p_level_bound_r5: assert property (@(posedge clk) disable iff (rst)
    tl <= TL_MAX);
  p_trap_inc_r2: assert property (@(posedge clk) disable iff (rst)
    take_trap |=> tl == $past(tl) + LVL_W'(1));
  p_full_hold_r5: assert property (@(posedge clk) disable iff (rst)
    reject_trap |=> $stable(tl));
  p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    reject_ret |=> tl == '0);
  p_trap_wins_r9: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> !take_ret);
endmodule

// File: rtl/tstk_frame_mem.sv
module tstk_frame_mem #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 5,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tstk_vector_gen.sv
module tstk_vector_gen #(
  parameter int ADDR_W = 64,
  parameter int TT_W   = 9
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [TT_W-1:0]   tt,
  input  logic              deep,
  output logic [ADDR_W-1:0] vec,
  output logic [ADDR_W-1:0] vec_next
);
  logic [14:0] low;
  logic        unused_low;

  assign unused_low = ^base[14:0];

  always_comb begin
    low      = 15'(tt) << 5;
    low[14]  = deep;
    vec      = {base[ADDR_W-1:15], low};
    vec_next = vec + ADDR_W'(4);
  end
endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
  import tstk_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TT_W   = 9,
  parameter int MAXTL  = 5,
  parameter int LVL_W  = $clog2(MAXTL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_req,
  input  logic [TT_W-1:0]   trap_type,
  input  logic              done_req,
  input  logic              retry_req,
  input  logic [ADDR_W-1:0] trap_base,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_npc,
  input  logic [7:0]        cur_ccr,
  input  logic [7:0]        cur_asi,
  input  logic [11:0]       cur_pstate,
  input  logic [7:0]        cur_cwp,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc,
  output logic [ADDR_W-1:0] redir_npc,
  output logic              restore_valid,
  output logic [11:0]       out_pstate,
  output logic [7:0]        ret_ccr,
  output logic [7:0]        ret_asi,
  output logic [7:0]        ret_cwp,
  output logic [TT_W-1:0]   ret_tt,
  output logic [LVL_W-1:0]  trap_level,
  output logic              err_full,
  output logic              err_empty
);
  // frame layout: {trap type, next PC, PC, packed state word}
  localparam int SW_LO  = 0;
  localparam int PC_LO  = SW_W;
  localparam int NPC_LO = SW_W + ADDR_W;
  localparam int TT_LO  = SW_W + 2 * ADDR_W;
  localparam int FR_W   = TT_LO + TT_W;

  logic [LVL_W-1:0]  tl;
  logic              take_trap, take_ret, ret_done, reject_trap, reject_ret;
  logic              red_entry, deep_entry;
  logic [ADDR_W-1:0] vec, vec_next;
  logic [FR_W-1:0]   wframe, rframe;
  logic [LVL_W-1:0]  rd_lvl;
  ctx_t              cur_ctx, saved_ctx;
  logic [ADDR_W-1:0] saved_pc, saved_npc;
  logic [TT_W-1:0]   saved_tt;

  tstk_level_ctrl #(.MAXTL(MAXTL), .LVL_W(LVL_W)) u_lvl (
    .clk(clk), .rst(rst), .trap_req(trap_req), .done_req(done_req),
    .retry_req(retry_req), .tl(tl), .take_trap(take_trap),
    .take_ret(take_ret), .ret_done(ret_done), .reject_trap(reject_trap),
    .reject_ret(reject_ret), .red_entry(red_entry), .deep_entry(deep_entry)
  );

  tstk_vector_gen #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_vec (
    .base(trap_base), .tt(trap_type), .deep(deep_entry),
    .vec(vec), .vec_next(vec_next)
  );

  always_comb begin
    cur_ctx.ccr = cur_ccr;
    cur_ctx.asi = cur_asi;
    cur_ctx.pst = cur_pstate;
    cur_ctx.cwp = cur_cwp;
    wframe = {trap_type, cur_npc, cur_pc, pack_ctx(cur_ctx)};
    rd_lvl = (tl == '0) ? '0 : tl - LVL_W'(1);
  end

  tstk_frame_mem #(.WIDTH(FR_W), .DEPTH(MAXTL), .AW(LVL_W)) u_mem (
    .clk(clk), .we(take_trap), .waddr(tl), .wdata(wframe),
    .raddr(rd_lvl), .rdata(rframe)
  );

  always_comb begin
    saved_ctx = unpack_ctx(rframe[SW_LO +: SW_W]);
    saved_pc  = rframe[PC_LO +: ADDR_W];
    saved_npc = rframe[NPC_LO +: ADDR_W];
    saved_tt  = rframe[TT_LO +: TT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid   <= 1'b0;
      redir_pc      <= '0;
      redir_npc     <= '0;
      restore_valid <= 1'b0;
      out_pstate    <= '0;
      ret_ccr       <= '0;
      ret_asi       <= '0;
      ret_cwp       <= '0;
      ret_tt        <= '0;
      err_full      <= 1'b0;
      err_empty     <= 1'b0;
    end else begin
      redir_valid   <= take_trap || take_ret;
      restore_valid <= take_ret;
      err_full      <= reject_trap;
      err_empty     <= reject_ret;
      if (take_trap) begin
        redir_pc   <= vec;
        redir_npc  <= vec_next;
        out_pstate <= red_entry ? (PST_ENTRY | PST_REDBIT) : PST_ENTRY;
      end else if (take_ret) begin
        redir_pc   <= ret_done ? saved_npc : saved_pc;
        redir_npc  <= ret_done ? saved_npc + ADDR_W'(4) : saved_npc;
        out_pstate <= saved_ctx.pst;
        ret_ccr    <= saved_ctx.ccr;
        ret_asi    <= saved_ctx.asi;
        ret_cwp    <= saved_ctx.cwp;
        ret_tt     <= saved_tt;
      end
    end
  end

  assign trap_level = tl;

  p_trap_npc_r4: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !restore_valid) |-> redir_npc == redir_pc + ADDR_W'(4));
  p_trap_priv_r3: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !restore_valid) |->
      (out_pstate[PST_PRIV] && out_pstate[PST_AG] && out_pstate[PST_PEF]));
  p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({redir_valid, err_full, err_empty}));
  p_ret_level_r6: assert property (@(posedge clk) disable iff (rst)
    take_ret |=> (restore_valid && trap_level == $past(trap_level) - LVL_W'(1)));
  p_vec_align_r4: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !restore_valid) |-> redir_pc[4:0] == 5'd0);
endmodule

// File: tb/tb_trap_state_stack.sv
`timescale 1ns/1ps
module tb_trap_state_stack;
  localparam int ADDR_W = 64;
  localparam int TT_W   = 9;
  localparam int MAXTL  = 5;
  localparam int LVL_W  = $clog2(MAXTL + 1);

  logic clk = 0;
  logic rst;
  logic trap_req, done_req, retry_req;
  logic [TT_W-1:0] trap_type;
  logic [ADDR_W-1:0] trap_base, cur_pc, cur_npc;
  logic [7:0] cur_ccr, cur_asi, cur_cwp;
  logic [11:0] cur_pstate;
  logic redir_valid, restore_valid, err_full, err_empty;
  logic [ADDR_W-1:0] redir_pc, redir_npc;
  logic [11:0] out_pstate;
  logic [7:0] ret_ccr, ret_asi, ret_cwp;
  logic [TT_W-1:0] ret_tt;
  logic [LVL_W-1:0] trap_level;

  always #10 clk = ~clk;

  trap_state_stack #(.ADDR_W(ADDR_W), .TT_W(TT_W), .MAXTL(MAXTL)) dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_type(trap_type),
    .done_req(done_req), .retry_req(retry_req), .trap_base(trap_base),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .cur_ccr(cur_ccr), .cur_asi(cur_asi),
    .cur_pstate(cur_pstate), .cur_cwp(cur_cwp), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .redir_npc(redir_npc), .restore_valid(restore_valid),
    .out_pstate(out_pstate), .ret_ccr(ret_ccr), .ret_asi(ret_asi),
    .ret_cwp(ret_cwp), .ret_tt(ret_tt), .trap_level(trap_level),
    .err_full(err_full), .err_empty(err_empty)
  );

  int checks = 0;
  int errors = 0;
  int mtl = 0;
  logic [ADDR_W-1:0] m_pc [MAXTL];
  logic [ADDR_W-1:0] m_npc [MAXTL];
  logic [7:0]  m_ccr [MAXTL];
  logic [7:0]  m_asi [MAXTL];
  logic [7:0]  m_cwp [MAXTL];
  logic [11:0] m_pst [MAXTL];
  logic [TT_W-1:0] m_tt [MAXTL];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] vecf(input logic [63:0] base, input int lvl,
                                       input logic [TT_W-1:0] tt);
    return (base & ~64'h7fff) | ((lvl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
  endfunction

  task automatic set_ctx(input int seed);
    cur_pc     = 64'h0000_1000_0000_0000 + 64'(seed) * 64'h40;
    cur_npc    = cur_pc + 64'h4 + 64'(seed % 3) * 64'h100;
    cur_ccr    = 8'(seed * 37 + 5);
    cur_asi    = 8'(seed * 11 + 128);
    cur_pstate = 12'(seed * 291 + 7);
    cur_cwp    = 8'(seed * 3 + 1);
  endtask

  task automatic pulse(input logic t, input logic d, input logic r, input logic [TT_W-1:0] tt);
    @(negedge clk);
    trap_req = t; done_req = d; retry_req = r; trap_type = tt;
    @(negedge clk);
    trap_req = 0; done_req = 0; retry_req = 0;
  endtask

  // trap with optional simultaneous return requests; R9 when returns present
  task automatic do_trap(input logic [TT_W-1:0] tt, input int seed, input logic d, input logic r);
    logic [63:0] v;
    int lvl;
    set_ctx(seed);
    lvl = mtl;
    v = vecf(trap_base, lvl, tt);
    if (lvl < MAXTL) begin
      m_pc[lvl] = cur_pc; m_npc[lvl] = cur_npc; m_ccr[lvl] = cur_ccr;
      m_asi[lvl] = cur_asi; m_cwp[lvl] = cur_cwp; m_pst[lvl] = cur_pstate;
      m_tt[lvl] = tt;
    end
    pulse(1'b1, d, r, tt);
    if (lvl < MAXTL) begin
      mtl = lvl + 1;
      check("R2 redir_valid", 64'(redir_valid), 64'd1);
      check("R2 trap_level", 64'(trap_level), 64'(mtl));
      check("R4 redir_pc", redir_pc, v);
      check("R4 redir_npc", redir_npc, v + 64'd4);
      check("R3 out_pstate", 64'(out_pstate),
            (lvl == MAXTL - 1) ? 64'h035 : 64'h015);
      check("R9 restore_valid low on trap", 64'(restore_valid), 64'd0);
    end else begin
      check("R5 redir_valid low", 64'(redir_valid), 64'd0);
      check("R5 err_full", 64'(err_full), 64'd1);
      check("R5 trap_level held", 64'(trap_level), 64'(MAXTL));
    end
  endtask

  task automatic do_ret(input logic d, input logic r);
    int lvl;
    lvl = mtl;
    pulse(1'b0, d, r, '0);
    if (lvl == 0) begin
      check("R8 redir_valid low", 64'(redir_valid), 64'd0);
      check("R8 err_empty", 64'(err_empty), 64'd1);
      check("R8 trap_level", 64'(trap_level), 64'd0);
    end else begin
      mtl = lvl - 1;
      check("R6 restore_valid", 64'(restore_valid), 64'd1);
      check("R6 trap_level", 64'(trap_level), 64'(mtl));
      if (d) begin
        check("R6 done pc", redir_pc, m_npc[mtl]);
        check("R6 done npc", redir_npc, m_npc[mtl] + 64'd4);
      end else begin
        check("R7 retry pc", redir_pc, m_pc[mtl]);
        check("R7 retry npc", redir_npc, m_npc[mtl]);
      end
      check("R10 ccr", 64'(ret_ccr), 64'(m_ccr[mtl]));
      check("R10 asi", 64'(ret_asi), 64'(m_asi[mtl]));
      check("R10 cwp", 64'(ret_cwp), 64'(m_cwp[mtl]));
      check("R10 pstate", 64'(out_pstate), 64'(m_pst[mtl]));
      check("R6 tt", 64'(ret_tt), 64'(m_tt[mtl]));
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; trap_req = 0; done_req = 0; retry_req = 0; trap_type = '0;
    trap_base = 64'hFFFF_0000_1234_5678;
    set_ctx(0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 trap_level", 64'(trap_level), 64'd0);
    check("R1 redir_valid", 64'(redir_valid), 64'd0);
    check("R1 restore_valid", 64'(restore_valid), 64'd0);
    check("R1 err flags", 64'({err_full, err_empty}), 64'd0);
    check("R1 redir_pc", redir_pc, 64'd0);
    check("R1 out_pstate", 64'(out_pstate), 64'd0);

    for (int round = 0; round < 2; round++) begin
      trap_base = (round == 0) ? 64'hFFFF_0000_1234_5678 : 64'h0000_00AB_CDEF_FFFF;
      for (int k = 0; k <= MAXTL; k++)
        do_trap(TT_W'((k * 97 + round * 255) % 512), k + round * 10, 1'b0, 1'b0);
      for (int k = 0; k <= MAXTL; k++)
        do_ret(((k + round) % 2) == 0, ((k + round) % 2) == 1);
    end

    // R9: trap beats return at level 0, then done beats retry
    do_trap(9'h1FF, 40, 1'b1, 1'b0);
    do_trap(9'h000, 41, 1'b0, 1'b1);
    do_ret(1'b1, 1'b1);
    do_ret(1'b0, 1'b1);
    // R9: refused trap at full stack still blocks a return
    for (int k = 0; k < MAXTL; k++) do_trap(TT_W'(k + 3), 50 + k, 1'b0, 1'b0);
    do_trap(9'h055, 60, 1'b1, 1'b0);
    for (int k = 0; k < MAXTL; k++) do_ret(1'b1, 1'b0);
    // R10: interleaved nesting
    do_trap(9'h011, 70, 1'b0, 1'b0);
    do_trap(9'h022, 71, 1'b0, 1'b0);
    do_ret(1'b0, 1'b1);
    do_trap(9'h033, 72, 1'b0, 1'b0);
    do_ret(1'b1, 1'b0);
    do_ret(1'b0, 1'b1);
    do_ret(1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule